// File: doc/BRIEF.md
# Dual-Context Program Counter Sequencer

This block holds the program counter of a core and works out the next instruction address. The core can fetch from three regions. Two are word-addressed local stores: a register file and a lookup RAM. The third is a byte-addressed shared main memory. The region the PC points into sets the sequential step and the scaling of relative branch offsets. As a result, one binary encoding of a relative branch reaches the same instruction distance wherever the code runs.

The block also contains a hardware repeat controller. A repeat instruction names a block of the instructions that follow it and gives an iteration count. In the local stores the controller loops with no penalty: it reloads the start address when the PC reaches the last instruction of the block. In main memory the same loop-back is a forced jump, and the block reports it on `redirect_o` so that the fetch side can flush. Decode, fetch and condition evaluation sit outside the block. Every input here is a plain control pin sampled on the cycle an instruction retires (`step_i` high). There is no handshake and no back-pressure path.

Top module: `pc_sequencer`

## Requirements
- R1: After reset `pc_o` is 0x00400, `ctx_hub_o` is 1 and `rep_active_o` is 0.
- R2: While `step_i` is 0 the PC holds its value and `redirect_o` stays 0, whatever the branch and repeat inputs are.
- R3: The PC below 0x00200 is the register-file region (`ctx_region_o`=0). The PC from 0x00200 to 0x003FF is the lookup region (`ctx_region_o`=1). The PC from 0x00400 up is main memory (`ctx_region_o`=2, `ctx_hub_o`=1). A sequential step adds 1 in the first two regions and 4 in main memory.
- R4: For a short branch (`br_long_i`=0), the offset is `br_off_i[8:0]` as a signed number. It is added sign-extended in the local regions and sign-extended then shifted left by 2 in main memory.
- R5: For a long branch (`br_long_i`=1), the offset is all 20 bits of `br_off_i` as a signed byte offset. It is added unchanged in main memory and arithmetically shifted right by 2 in the local regions.
- R6: A taken branch (`br_valid_i` and `br_taken_i`) has priority over the repeat loop-back and the sequential step. It asserts `redirect_o` and cancels any active repeat. A branch that is not taken steps sequentially.
- R7: All PC arithmetic wraps modulo 2^20.
- R8: A repeat (`rep_start_i`) has length L in `rep_len_i`, with L at least 1. It covers the L instructions after the repeat. With a count N of 2 or more, the block runs N times and execution then continues after its last instruction. `rep_active_o` is 1 until the final pass ends.
- R9: A loop-back taken in main memory asserts `redirect_o`. A loop-back in the local regions does not.
- R10: A count of 0 skips the block: the next PC is the repeat's PC plus (L+1) steps, with `redirect_o` asserted. A count of 1 runs the block once, with no loop-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | The instruction at `pc_o` retires this cycle |
| br_valid_i | input | 1 | The retiring instruction is a relative branch |
| br_taken_i | input | 1 | The branch condition holds |
| br_long_i | input | 1 | 1 = 20-bit byte offset, 0 = 9-bit instruction offset |
| br_off_i | input | 20 | Branch offset (short form uses bits 8:0) |
| rep_start_i | input | 1 | The retiring instruction is a repeat |
| rep_len_i | input | 9 | Number of instructions in the repeat block |
| rep_count_i | input | COUNT_W | Iteration count |
| pc_o | output | 20 | Current PC |
| next_pc_o | output | 20 | PC after this cycle |
| ctx_hub_o | output | 1 | The PC is in main memory |
| ctx_region_o | output | 2 | Region of the PC: 0 register file, 1 lookup, 2 main |
| redirect_o | output | 1 | This cycle's transfer needs a fetch redirect |
| rep_active_o | output | 1 | A repeat loop is armed |

## Verification
The bench builds the block with COUNT_W = 4 and defaults elsewhere. That makes the largest count, 15, cheap to run to completion, so the saturating end of the counter is exercised. The directed sequence moves the PC through all three regions using only branches. It wraps below zero and past the top of the 20-bit space. It compares loop-backs in the local regions and in main memory, counting the redirects in each.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [1:0] {
    RGN_CORE = 2'd0,
    RGN_LUT  = 2'd1,
    RGN_MAIN = 2'd2
  } region_e;
endpackage

// File: rtl/pcseq_region.sv
module pcseq_region
  import pcseq_pkg::*;
#(
  parameter int PC_W      = 20,
  parameter int LUT_BASE  = 'h200,
  parameter int MAIN_BASE = 'h400
) (
  input  logic [PC_W-1:0] pc,
  output region_e         region,
  output logic            hub
);
  always_comb begin
    if (pc >= PC_W'(MAIN_BASE))     region = RGN_MAIN;
    else if (pc >= PC_W'(LUT_BASE)) region = RGN_LUT;
    else                            region = RGN_CORE;
    hub = (region == RGN_MAIN);
  end
endmodule

// File: rtl/pcseq_branch.sv
module pcseq_branch #(
  parameter int PC_W    = 20,
  parameter int SHORT_W = 9,
  parameter int LONG_W  = 20
) (
  input  logic [PC_W-1:0]   pc,
  input  logic              hub,
  input  logic              is_long,
  input  logic [LONG_W-1:0] off,
  output logic [PC_W-1:0]   target
);
  localparam int SEXT = PC_W - SHORT_W;
  localparam int LEXT = PC_W - LONG_W;

  logic [PC_W-1:0] short_x;
  logic [PC_W-1:0] long_x;
  logic [PC_W-1:0] delta;

  assign short_x = {{SEXT{off[SHORT_W-1]}}, off[SHORT_W-1:0]};

  generate
    if (LEXT > 0) begin : g_lext
      assign long_x = {{LEXT{off[LONG_W-1]}}, off};
    end else begin : g_lsame
      assign long_x = off[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    if (is_long) delta = hub ? long_x : PC_W'($signed(long_x) >>> 2);
    else         delta = hub ? (short_x << 2) : short_x;
    target = pc + delta;
  end
endmodule

// File: rtl/pcseq_repeat.sv
module pcseq_repeat #(
  parameter int PC_W    = 20,
  parameter int LEN_W   = 9,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               cancel,
  input  logic               load,
  input  logic [PC_W-1:0]    pc,
  input  logic               hub,
  input  logic [LEN_W-1:0]   len,
  input  logic [COUNT_W-1:0] count,
  output logic               active,
  output logic               loop_back,
  output logic [PC_W-1:0]    start_addr,
  output logic [PC_W-1:0]    skip_addr
);
  logic [PC_W-1:0]    end_addr;
  logic [COUNT_W-1:0] remain;
  logic [PC_W-1:0]    len_span;
  logic [PC_W-1:0]    one_step;
  logic               hit;

  always_comb begin
    one_step  = hub ? PC_W'(4) : PC_W'(1);
    len_span  = hub ? (PC_W'(len) << 2) : PC_W'(len);
    skip_addr = pc + len_span + one_step;
    hit       = active && (pc == end_addr);
    loop_back = hit && (remain > COUNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      start_addr <= '0;
      end_addr   <= '0;
      remain     <= '0;
    end else if (cancel) begin
      active <= 1'b0;
    end else if (load) begin
      active     <= (count >= COUNT_W'(2));
      start_addr <= pc + one_step;
      end_addr   <= pc + len_span;
      remain     <= count;
    end else if (step && hit) begin
      if (remain > COUNT_W'(1)) remain <= remain - COUNT_W'(1);
      else                      active <= 1'b0;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W      = 20,
  parameter int SHORT_W   = 9,
  parameter int LONG_W    = 20,
  parameter int LEN_W     = 9,
  parameter int COUNT_W   = 16,
  parameter int LUT_BASE  = 'h200,
  parameter int MAIN_BASE = 'h400,
  parameter int RESET_PC  = 'h400
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic               br_valid_i,
  input  logic               br_taken_i,
  input  logic               br_long_i,
  input  logic [LONG_W-1:0]  br_off_i,
  input  logic               rep_start_i,
  input  logic [LEN_W-1:0]   rep_len_i,
  input  logic [COUNT_W-1:0] rep_count_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    next_pc_o,
  output logic               ctx_hub_o,
  output logic [1:0]         ctx_region_o,
  output logic               redirect_o,
  output logic               rep_active_o
);
  region_e         region;
  logic            hub;
  logic [PC_W-1:0] br_target;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] loop_start;
  logic [PC_W-1:0] skip_pc;
  logic            loop_back;
  logic            br_fire;
  logic            rep_load;

  pcseq_region #(.PC_W(PC_W), .LUT_BASE(LUT_BASE), .MAIN_BASE(MAIN_BASE)) u_region (
    .pc(pc_o), .region(region), .hub(hub)
  );

  pcseq_branch #(.PC_W(PC_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_branch (
    .pc(pc_o), .hub(hub), .is_long(br_long_i), .off(br_off_i), .target(br_target)
  );

  assign br_fire  = step_i && br_valid_i && br_taken_i;
  assign rep_load = step_i && rep_start_i && !br_fire;

  pcseq_repeat #(.PC_W(PC_W), .LEN_W(LEN_W), .COUNT_W(COUNT_W)) u_repeat (
    .clk(clk), .rst_n(rst_n), .step(step_i), .cancel(br_fire), .load(rep_load),
    .pc(pc_o), .hub(hub), .len(rep_len_i), .count(rep_count_i),
    .active(rep_active_o), .loop_back(loop_back),
    .start_addr(loop_start), .skip_addr(skip_pc)
  );

  assign seq_pc = pc_o + (hub ? PC_W'(4) : PC_W'(1));

  always_comb begin
    next_pc_o  = pc_o;
    redirect_o = 1'b0;
    if (step_i) begin
      if (br_fire) begin
        next_pc_o  = br_target;
        redirect_o = 1'b1;
      end else if (rep_start_i) begin
        if (rep_count_i == '0) begin
          next_pc_o  = skip_pc;
          redirect_o = 1'b1;
        end else begin
          next_pc_o = seq_pc;
        end
      end else if (loop_back) begin
        next_pc_o  = loop_start;
        redirect_o = hub;
      end else begin
        next_pc_o = seq_pc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_o <= PC_W'(RESET_PC);
    else        pc_o <= next_pc_o;
  end

  assign ctx_hub_o    = hub;
  assign ctx_region_o = region;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker #(
  parameter int PC_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step_i,
  input logic            br_valid_i,
  input logic            br_taken_i,
  input logic            rep_start_i,
  input logic [PC_W-1:0] pc_o,
  input logic            ctx_hub_o,
  input logic            redirect_o,
  input logic            rep_active_o
);
  logic plain;
  assign plain = step_i && !(br_valid_i && br_taken_i) && !rep_start_i && !rep_active_o;

  a_r2_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> pc_o == $past(pc_o));

  a_r2_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |-> !redirect_o);

  a_r3_local_plus1: assert property (@(posedge clk) disable iff (!rst_n)
    plain && !ctx_hub_o |=> pc_o == $past(pc_o) + PC_W'(1));

  a_r3_main_plus4: assert property (@(posedge clk) disable iff (!rst_n)
    plain && ctx_hub_o |=> pc_o == $past(pc_o) + PC_W'(4));

  a_r6_branch_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && br_valid_i && br_taken_i |-> redirect_o);

  a_r6_branch_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && br_valid_i && br_taken_i |=> !rep_active_o);

  a_r9_local_loop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && rep_active_o && !ctx_hub_o && !(br_valid_i && br_taken_i) && !rep_start_i
      |-> !redirect_o);
endmodule

bind pc_sequencer pcseq_checker #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_valid_i(br_valid_i),
  .br_taken_i(br_taken_i), .rep_start_i(rep_start_i), .pc_o(pc_o),
  .ctx_hub_o(ctx_hub_o), .redirect_o(redirect_o), .rep_active_o(rep_active_o)
);

// File: tb/tb_pc_sequencer.sv
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 1'b0, br_valid_i = 1'b0, br_taken_i = 1'b0, br_long_i = 1'b0;
  logic [19:0] br_off_i = '0;
  logic        rep_start_i = 1'b0;
  logic [8:0]  rep_len_i = '0;
  logic [3:0]  rep_count_i = '0;
  logic [19:0] pc_o, next_pc_o;
  logic        ctx_hub_o, redirect_o, rep_active_o;
  logic [1:0]  ctx_region_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic last_redir;

  always #10 clk = ~clk;

  pc_sequencer #(.COUNT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_valid_i(br_valid_i),
    .br_taken_i(br_taken_i), .br_long_i(br_long_i), .br_off_i(br_off_i),
    .rep_start_i(rep_start_i), .rep_len_i(rep_len_i), .rep_count_i(rep_count_i),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .ctx_hub_o(ctx_hub_o),
    .ctx_region_o(ctx_region_o), .redirect_o(redirect_o), .rep_active_o(rep_active_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic st, input logic bv, input logic bt, input logic bl,
                     input logic [19:0] off, input logic rs, input logic [8:0] len,
                     input logic [3:0] cnt);
    @(negedge clk);
    step_i = st; br_valid_i = bv; br_taken_i = bt; br_long_i = bl; br_off_i = off;
    rep_start_i = rs; rep_len_i = len; rep_count_i = cnt;
    #1 last_redir = redirect_o;
    @(posedge clk);
    #1;
    step_i = 0; br_valid_i = 0; br_taken_i = 0; rep_start_i = 0;
  endtask

  task automatic seq();                          cyc(1, 0, 0, 0, '0, 0, '0, '0); endtask
  task automatic jmp(input logic lng, input logic [19:0] off); cyc(1, 1, 1, lng, off, 0, '0, '0); endtask
  task automatic rep(input logic [8:0] len, input logic [3:0] cnt); cyc(1, 0, 0, 0, '0, 1, len, cnt); endtask

  task automatic t_reset();
    chk("R1 pc", pc_o, 32'h400);
    chk("R1 ctx_hub", ctx_hub_o, 1);
    chk("R1 rep_active", rep_active_o, 0);
  endtask

  task automatic t_hold();
    cyc(0, 1, 1, 1, 20'h00100, 1, 9'd2, 4'd3);
    chk("R2 hold pc", pc_o, 32'h400);
    chk("R2 no redirect", last_redir, 0);
    chk("R2 no repeat", rep_active_o, 0);
  endtask

  task automatic t_main_flow();
    seq(); chk("R3 main +4", pc_o, 32'h404);
    seq(); chk("R3 main +4 again", pc_o, 32'h408);
    jmp(0, 20'h001FF); chk("R4 main short -1", pc_o, 32'h404);
    jmp(0, 20'h00003); chk("R4 main short +3", pc_o, 32'h410);
    jmp(1, 20'hFFC00); chk("R5 main long bytes", pc_o, 32'h010);
    chk("R3 region core", ctx_region_o, 0);
  endtask

  task automatic t_local_flow();
    seq(); chk("R3 core +1", pc_o, 32'h011);
    jmp(0, 20'h001FF); chk("R4 core short -1", pc_o, 32'h010);
    jmp(1, 20'h00200); chk("R5 core long >>2", pc_o, 32'h090);
    jmp(1, 20'hFFFF0); chk("R5 core long negative", pc_o, 32'h08C);
    jmp(1, 20'h005D0); chk("R5 into lookup", pc_o, 32'h200);
    chk("R3 region lut", ctx_region_o, 1);
    chk("R3 lut not hub", ctx_hub_o, 0);
    seq(); chk("R3 lut +1", pc_o, 32'h201);
    cyc(1, 1, 0, 0, 20'h00040, 0, '0, '0);
    chk("R6 not taken steps", pc_o, 32'h202);
    chk("R6 not taken no redirect", last_redir, 0);
  endtask

  task automatic t_wrap();
    jmp(1, 20'hFF800); chk("R5 lut long back", pc_o, 32'h002);
    jmp(0, 20'h001FD); chk("R7 wrap below zero", pc_o, 32'hFFFFF);
    chk("R3 region main at top", ctx_region_o, 2);
    seq(); chk("R7 wrap past top", pc_o, 32'h00003);
  endtask

  task automatic t_local_repeat();
    int redirs = 0;
    logic [19:0] exp_seq [7] = '{20'h004, 20'h005, 20'h004, 20'h005, 20'h004, 20'h005, 20'h006};
    rep(9'd2, 4'd3);
    chk("R8 local rep armed", rep_active_o, 1);
    chk("R8 local rep first", pc_o, 32'h004);
    for (int i = 1; i < 7; i++) begin
      seq();
      if (last_redir) redirs++;
      chk("R8 local rep sequence", pc_o, exp_seq[i]);
    end
    chk("R9 local loop no redirect", redirs, 0);
    chk("R8 local rep done", rep_active_o, 0);
  endtask

  task automatic t_main_repeat();
    jmp(1, 20'h00FE8); chk("R5 core to main", pc_o, 32'h400);
    rep(9'd1, 4'd2); chk("R8 main rep first", pc_o, 32'h404);
    seq(); chk("R8 main loop back", pc_o, 32'h404);
    chk("R9 main loop redirect", last_redir, 1);
    seq(); chk("R8 main rep exit", pc_o, 32'h408);
    chk("R9 main exit no redirect", last_redir, 0);
    chk("R8 main rep done", rep_active_o, 0);
  endtask

  task automatic t_counts();
    rep(9'd3, 4'd0); chk("R10 count0 skip", pc_o, 32'h418);
    chk("R10 count0 redirect", last_redir, 1);
    chk("R10 count0 inactive", rep_active_o, 0);
    rep(9'd1, 4'd1); chk("R10 count1 enter", pc_o, 32'h41C);
    seq(); chk("R10 count1 no loop", pc_o, 32'h420);
    chk("R10 count1 no redirect", last_redir, 0);
  endtask

  task automatic t_priority();
    rep(9'd2, 4'd5); chk("R6 rep setup", pc_o, 32'h424);
    seq(); chk("R6 at block end", pc_o, 32'h428);
    jmp(0, 20'h00002); chk("R6 branch beats loop", pc_o, 32'h430);
    chk("R6 branch redirect", last_redir, 1);
    chk("R6 branch cancels rep", rep_active_o, 0);
  endtask

  task automatic t_max_count();
    int loops = 0;
    rep(9'd1, 4'd15); chk("R8 max count enter", pc_o, 32'h434);
    for (int i = 0; i < 15; i++) begin
      seq();
      if (last_redir) loops++;
    end
    chk("R8 max count loop-backs", loops, 14);
    chk("R8 max count exit pc", pc_o, 32'h438);
    chk("R8 max count done", rep_active_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_hold();
    t_main_flow();
    t_local_flow();
    t_wrap();
    t_local_repeat();
    t_main_repeat();
    t_counts();
    t_priority();
    t_max_count();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule